// File: doc/BRIEF.md
# Circular Buffer Audio Delay Line

This block delays a stream of parallel audio words by a programmable whole number of sample periods. The samples sit in a circular buffer whose length is a power of two, N = 2^AW words. A write pointer counter names the slot for each new sample and advances once per period. It wraps on its own because the buffer length is a power of two. A stored offset is added to the write pointer, modulo N, to form the read address.

Each sample period lasts four clocks, one for each phase in a fixed order. The first phase starts a conversion, then the buffer is read, then written, and last the pointer and offset are updated. A strobe output marks each phase, so an outside converter can run in step with the block. The word read from the buffer is registered and held on the output for the rest of the period, and a one-clock valid pulse marks it. The offset is a plain input. Its value is taken once per period, so a change never lands in the middle of a period.

The read address is the write pointer plus an offset `ofs`. The delay is therefore D = (N − ofs) mod N periods, and an offset of zero gives a full N periods. For a delay of D, with 1 ≤ D ≤ N, program `ofs = (N − D) mod N`.

Top module: `cbuf_delay`

## Requirements
- R1: Every sample period is four clocks. The phases come in the order conversion start (`conv_start`), buffer read (`rd_strobe`), buffer write (`wr_strobe`) and pointer update (`upd_strobe`). Exactly one strobe is high in each clock, and after reset the first clock is the conversion-start phase.
- R2: The write pointer is 0 after reset. It advances by one at each pointer-update phase and wraps from N−1 to 0.
- R3: The read address is (write pointer + offset register) mod N. With offset `ofs`, the output in period j is the sample written in period j − D, where D = (N − ofs) mod N, and D = N when the result is zero. This holds across pointer wraparound, including when the read address is numerically above the write address.
- R4: Within a period the read comes before the write. An offset of 0 therefore returns the sample from N periods earlier and never the sample being written in the same period.
- R5: The offset register is 0 after reset. It loads `ofs_in` only at the pointer-update phase, and the new value first steers the read of the next period. A change of `ofs_in` during the conversion-start, read or write phase has no effect on the read of the current period.
- R6: `rd_data` changes only at the clock that ends the read phase, and then holds for the rest of the period. `rd_valid` is high for exactly one clock per period, during the write phase.
- R7: After any reset, every buffer slot reads as zero until it is written again. This includes slots written before a reset that comes in the middle of a run.
- R8: The sample stored in a period is the value on `smp_in` at the clock that ends the write phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; four clocks make one sample period |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_in | input | DW | Incoming sample, stored during the write phase |
| ofs_in | input | AW | Read offset; taken at the pointer-update phase |
| conv_start | output | 1 | Conversion-start phase strobe |
| rd_strobe | output | 1 | Buffer-read phase strobe |
| wr_strobe | output | 1 | Buffer-write phase strobe |
| upd_strobe | output | 1 | Pointer-update phase strobe |
| rd_data | output | DW | Delayed sample, held for the period |
| rd_valid | output | 1 | One-clock pulse marking a new `rd_data` |

## Verification
The hardest case to reach from the ports is an offset change that arrives in the middle of a period. The port only matters at one clock in four, and the read that the change must not disturb happens earlier in the same period. The stimulus drives a deliberately wrong offset during the conversion-start and read phases and the intended one from the write phase on. The bench then checks that the current output still follows the old offset and the next period follows the new one. A reset in the middle of a run, over slots that already hold data, shows that the zero-until-written rule survives reset. Runs longer than N periods carry the pointer through wraparound.

// File: rtl/cbuf_delay.sv
`timescale 1ns/1ps
module cbuf_delay #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] smp_in,
  input  logic [AW-1:0] ofs_in,
  output logic          conv_start,
  output logic          rd_strobe,
  output logic          wr_strobe,
  output logic          upd_strobe,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  localparam int N = 1 << AW;
  localparam logic [1:0] PH_CONV = 2'd0, PH_READ = 2'd1, PH_WRITE = 2'd2, PH_UPD = 2'd3;

  logic [1:0]    ph;
  logic [AW-1:0] wptr, ofs_q, raddr;
  logic [DW-1:0] mem [N];
  logic [N-1:0]  filled;

  assign conv_start = (ph == PH_CONV);
  assign rd_strobe  = (ph == PH_READ);
  assign wr_strobe  = (ph == PH_WRITE);
  assign upd_strobe = (ph == PH_UPD);
  assign raddr      = wptr + ofs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ph <= PH_CONV;
    else        ph <= ph + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr     <= '0;
      ofs_q    <= '0;
      filled   <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_strobe;
      if (rd_strobe) rd_data <= filled[raddr] ? mem[raddr] : '0;
      if (wr_strobe) filled[wptr] <= 1'b1;
      if (upd_strobe) begin
        wptr  <= wptr + 1'b1;
        ofs_q <= ofs_in;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_strobe) mem[wptr] <= smp_in;
  end

  // phase order
  p_conv_then_read_r1: assert property (@(posedge clk) disable iff (!rst_n) conv_start |=> rd_strobe);
  p_read_then_write_r1: assert property (@(posedge clk) disable iff (!rst_n) rd_strobe |=> wr_strobe);
  p_write_then_upd_r1: assert property (@(posedge clk) disable iff (!rst_n) wr_strobe |=> upd_strobe);
  p_upd_then_conv_r1: assert property (@(posedge clk) disable iff (!rst_n) upd_strobe |=> conv_start);

  // pointer movement
  p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe |=> wptr == $past(wptr) + 1'b1);
  p_ptr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_strobe |=> $stable(wptr));

  // offset only moves at update
  p_ofs_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_strobe |=> $stable(ofs_q));

  // output timing
  p_valid_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> rd_valid);
  p_valid_only_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> wr_strobe);
  p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> $stable(rd_data));

  // unwritten slots read zero
  p_unwritten_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !filled[raddr]) |=> rd_data == '0);
endmodule

// File: tb/sim_cbuf_delay.sv
`timescale 1ns/1ps
module sim_cbuf_delay;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int N  = 1 << AW;
  localparam int NV = 24;
  // each entry: {sample[15:0], offset[3:0]}
  localparam logic [19:0] VEC [NV] = '{
    {16'h1111, 4'd15}, {16'h2222, 4'd15}, {16'h3333, 4'd15}, {16'h4444, 4'd13},
    {16'h5555, 4'd13}, {16'h6666, 4'd13}, {16'h7777, 4'd1},  {16'h8888, 4'd1},
    {16'h9999, 4'd8},  {16'hAAAA, 4'd8},  {16'hBBBB, 4'd8},  {16'hCCCC, 4'd15},
    {16'hDDDD, 4'd15}, {16'hEEEE, 4'd2},  {16'h0F0F, 4'd2},  {16'hF0F0, 4'd14},
    {16'h1234, 4'd14}, {16'h5678, 4'd14}, {16'h9ABC, 4'd0},  {16'hDEF0, 4'd0},
    {16'h0001, 4'd3},  {16'h8000, 4'd3},  {16'hFFFF, 4'd15}, {16'h7FFF, 4'd9}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] smp_in = '0;
  logic [AW-1:0] ofs_in = '0;
  logic conv_start, rd_strobe, wr_strobe, upd_strobe, rd_valid;
  logic [DW-1:0] rd_data;

  int checks = 0, errors = 0;
  int hist [512];
  int pidx = 0;
  int off_eff = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cbuf_delay #(.DW(DW), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .ofs_in(ofs_in),
    .conv_start(conv_start), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
    .upd_strobe(upd_strobe), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int expect_out();
    int d;
    d = (N - off_eff) % N;
    if (d == 0) d = N;
    if (pidx - d >= 0) return hist[pidx - d];
    return 0;
  endfunction

  // Starts and ends at the negedge inside the conversion-start phase.
  task automatic run_period(input logic [DW-1:0] s, input logic [AW-1:0] o,
                            input logic [AW-1:0] early, input string req);
    int e;
    e = expect_out();
    chk(conv_start && !rd_strobe && !wr_strobe && !upd_strobe, "R1 conv phase",
        {conv_start, rd_strobe, wr_strobe, upd_strobe}, 4'b1000);
    smp_in = s;
    ofs_in = early;
    @(negedge clk);
    chk(rd_strobe && !conv_start && !rd_valid, "R1/R6 read phase",
        {rd_strobe, rd_valid}, 2'b10);
    @(negedge clk);
    ofs_in = o;
    chk(wr_strobe && rd_valid, "R1/R6 write phase valid", {wr_strobe, rd_valid}, 2'b11);
    chk(rd_data == DW'(e), req, rd_data, e);
    @(negedge clk);
    chk(upd_strobe && !rd_valid, "R1/R6 update phase", {upd_strobe, rd_valid}, 2'b10);
    chk(rd_data == DW'(e), "R6 data held", rd_data, e);
    @(negedge clk);
    hist[pidx] = int'(s);
    pidx++;
    off_eff = int'(o);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    pidx = 0;
    off_eff = 0;
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk(rd_data == '0 && !rd_valid, "R7 reset output", {rd_valid, rd_data}, 0);
    chk(conv_start, "R1 first phase after reset", conv_start, 1);

    // table walk; offsets vary, pointer wraps past N (R2, R3, R8)
    for (int i = 0; i < NV; i++) begin
      run_period(VEC[i][19:4], VEC[i][3:0], VEC[i][3:0], "R3 delayed sample");
    end

    // offset change in the middle of a period does not steer this read (R5)
    run_period(16'hA5A5, 4'd15, 4'd7, "R5 mid-period offset ignored");
    run_period(16'h5A5A, 4'd15, 4'd3, "R5 mid-period offset ignored");
    run_period(16'h3C3C, 4'd12, 4'd12, "R5 new offset next period");

    // zero offset: N periods of delay, never the current sample (R4)
    for (int i = 0; i < N + 3; i++) begin
      run_period(DW'(16'h6000 + i), 4'd0, 4'd0, "R4 zero offset full buffer");
    end

    // reset in the middle of a run: old contents read zero (R7), pointer back to 0 (R2)
    do_reset();
    chk(rd_data == '0 && !rd_valid, "R7 reset output mid-run", {rd_valid, rd_data}, 0);
    run_period(16'hBEEF, 4'd15, 4'd15, "R7 slot 0 zero after reset");
    run_period(16'hCAFE, 4'd15, 4'd15, "R2 delay one after reset");
    for (int i = 0; i < 4; i++) begin
      run_period(DW'(16'h0100 + i), 4'd10, 4'd10, "R7 unwritten slots zero");
    end
    for (int i = 0; i < N; i++) begin
      run_period(DW'(16'h0200 + i), 4'd10, 4'd10, "R3 wrap after reset");
    end

    finish_up();
  end
endmodule